// File: doc/BRIEF.md
# Retransmit-Capable Byte-Plus-Parity FIFO

This block is a single-clock first-in/first-out buffer for 9-bit words (eight data bits plus one spare bit that is often used for parity or a control mark). Words are written and read through ring pointers, so the user never supplies an address. The depth is a parameter, meant to be 256, 512 or 1024 words. Write and read strobes are sampled on the rising clock edge. The block reports empty, full and more-than-half-full status.

A rewind input moves the read pointer back to the first location and leaves the write pointer where it is. The whole content written since reset can then be sent again, as long as fewer than a full depth of words has been written. Read data is registered. It is marked valid only in the cycle that follows an accepted read. In every other cycle it is driven to zero.

Top module: `fifo9_rt`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `empty` is 1 and `full`, `halfFull` and `rdValid` are 0.
- R2: Words come out in the order they were written. An accepted read at clock edge k presents the word on `rdData` with `rdValid`=1 in the cycle after edge k.
- R3: `empty` is 1 exactly when the stored count is zero. A read strobe while empty moves nothing: `rdValid` stays 0 and the next accepted read still returns the oldest word.
- R4: With no reads, `full` rises after exactly DEPTH accepted writes. A write strobe while full (without a read) is dropped: the stored words are unchanged.
- R5: `halfFull` is 1 exactly when the stored count is greater than DEPTH/2. It rises on the write that makes the count DEPTH/2+1. It falls on the read that brings the count down to DEPTH/2.
- R6: A rewind strobe with both `wrEn` and `rdEn` low sets the read pointer to location 0 and keeps the write pointer. All flags are then recomputed from the stored count, which becomes the write pointer value. The following reads replay from the first word written after reset.
- R7: A rewind strobe in a cycle where `wrEn` or `rdEn` is high is ignored. The read and write in that cycle proceed as usual.
- R8: A read and a write in the same cycle while empty perform only the write, so `rdValid` stays 0 and `empty` falls. A read and a write in the same cycle while full perform only the read, so `full` falls and the incoming word is dropped.
- R9: In any cycle not preceded by an accepted read, `rdValid` is 0 and `rdData` is 0.
- R10: A read and a write in the same cycle while neither empty nor full both take effect. The count, and so every flag, is unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Synchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrData | input | 9 | Word to store |
| rdEn | input | 1 | Read strobe |
| rewind | input | 1 | Return the read pointer to location 0 |
| rdData | output | 9 | Registered read word, zero when not valid |
| rdValid | output | 1 | `rdData` holds a word read in the previous cycle |
| empty | output | 1 | No words stored |
| full | output | 1 | DEPTH words stored |
| halfFull | output | 1 | More than DEPTH/2 words stored |

## Verification
A read and a write can arrive in the same cycle. A rewind can also be requested alongside either of them. The bench provokes the overlapping cases at both boundaries: a read and a write together while empty, while full, and in the open middle range; and rewinds raised together with an active read or write strobe. A reference model in the bench follows the requirement rules (write dropped when full, read dropped when empty, rewind taken only when both strobes are low). Every cycle it compares the flags, `rdValid` and `rdData` against that model, including long random runs where all three strobes overlap freely.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;

  // Strobes the control unit hands to the storage datapath each cycle.
  typedef struct packed {
    logic wrDo;   // store wrData at the write pointer
    logic rdDo;   // fetch the word at the read pointer
  } fifoStrobes_t;

endpackage

// File: rtl/fifo9_ctrl.sv
module fifo9_ctrl
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          rdEn,
  input  logic          rewind,
  output fifoStrobes_t  strobes,
  output logic [AW-1:0] wrPtr,
  output logic [AW-1:0] rdPtr,
  output logic          empty,
  output logic          full,
  output logic          halfFull
);

  localparam int CW = AW + 1;
  localparam logic [CW-1:0] CNT_FULL = CW'(DEPTH);
  localparam logic [CW-1:0] CNT_HALF = CW'(DEPTH / 2);
  localparam logic [AW-1:0] PTR_LAST = AW'(DEPTH - 1);

  logic [CW-1:0] count;
  logic [CW-1:0] countNext;
  logic [AW-1:0] wrPtrNext;
  logic [AW-1:0] rdPtrNext;
  logic          rewindTake;

  // Ring pointer advance; a power-of-two depth wraps for free.
  function automatic logic [AW-1:0] ptrInc(input logic [AW-1:0] p);
    if ((DEPTH & (DEPTH - 1)) == 0) return p + 1'b1;
    else                            return (p == PTR_LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    strobes.wrDo = wrEn && !full;
    strobes.rdDo = rdEn && !empty;
    rewindTake   = rewind && !wrEn && !rdEn;
  end

  always_comb begin
    wrPtrNext = strobes.wrDo ? ptrInc(wrPtr) : wrPtr;
    rdPtrNext = strobes.rdDo ? ptrInc(rdPtr) : rdPtr;
    countNext = count;
    if (rewindTake) begin
      rdPtrNext = '0;
      countNext = {1'b0, wrPtr};
    end else begin
      case ({strobes.wrDo, strobes.rdDo})
        2'b10:   countNext = count + 1'b1;
        2'b01:   countNext = count - 1'b1;
        default: countNext = count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      empty    <= 1'b1;
      full     <= 1'b0;
      halfFull <= 1'b0;
    end else begin
      wrPtr    <= wrPtrNext;
      rdPtr    <= rdPtrNext;
      count    <= countNext;
      empty    <= (countNext == '0);
      full     <= (countNext == CNT_FULL);
      halfFull <= (countNext > CNT_HALF);
    end
  end

endmodule

// File: rtl/fifo9_store.sv
module fifo9_store
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  fifoStrobes_t     strobes,
  input  logic [AW-1:0]    wrPtr,
  input  logic [AW-1:0]    rdPtr,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobes.wrDo) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (strobes.rdDo) begin
      rdData  <= mem[rdPtr];
      rdValid <= 1'b1;
    end else begin
      rdData  <= '0;
      rdValid <= 1'b0;
    end
  end

endmodule

// File: rtl/fifo9_rt.sv
module fifo9_rt
  import fifo9_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int WIDTH = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  input  logic             rewind,
  output logic [WIDTH-1:0] rdData,
  output logic             rdValid,
  output logic             empty,
  output logic             full,
  output logic             halfFull
);

  localparam int AW = $clog2(DEPTH);

  fifoStrobes_t  strobes;
  logic [AW-1:0] wrPtr;
  logic [AW-1:0] rdPtr;

  fifo9_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rewind(rewind),
    .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .empty(empty), .full(full), .halfFull(halfFull)
  );

  fifo9_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrPtr(wrPtr), .rdPtr(rdPtr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid)
  );

endmodule

// File: rtl/fifo9_rt_chk.sv
module fifo9_rt_chk #(
  parameter int WIDTH = 9
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic             rdEn,
  input logic [WIDTH-1:0] rdData,
  input logic             rdValid,
  input logic             empty,
  input logic             full,
  input logic             halfFull
);

  // R3
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(empty && full));

  // R3
  empty_read_blocked_chk: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn) |=> !rdValid);

  // R2
  read_presents_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && rdEn) |=> rdValid);

  // R4
  full_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && wrEn && !rdEn) |=> full);

  // R5
  full_implies_half_chk: assert property (@(posedge clk) disable iff (!rstN)
    full |-> halfFull);

  // R8
  empty_rw_write_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (empty && rdEn && wrEn) |=> (!empty && !rdValid));

  // R8
  full_rw_read_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (full && rdEn && wrEn) |=> (!full && rdValid));

  // R9
  idle_data_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    !rdValid |-> (rdData == '0));

  // R10
  mid_rw_flags_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!empty && !full && rdEn && wrEn) |=> $stable({empty, full, halfFull}));

endmodule

bind fifo9_rt fifo9_rt_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .rdData(rdData),
  .rdValid(rdValid), .empty(empty), .full(full), .halfFull(halfFull)
);

// File: tb/sim_fifo9_rt.sv
`timescale 1ns/1ps
module sim_fifo9_rt;

  localparam int DEPTH = 256;
  localparam int WIDTH = 9;
  localparam int HALF  = DEPTH / 2;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             wrEn = 1'b0;
  logic [WIDTH-1:0] wrData = '0;
  logic             rdEn = 1'b0;
  logic             rewind = 1'b0;
  logic [WIDTH-1:0] rdData;
  logic             rdValid;
  logic             empty;
  logic             full;
  logic             halfFull;

  always #2.5 clk = ~clk;

  fifo9_rt #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData), .rdEn(rdEn),
    .rewind(rewind), .rdData(rdData), .rdValid(rdValid),
    .empty(empty), .full(full), .halfFull(halfFull)
  );

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  // Reference model state, driven by the requirement rules only.
  logic [WIDTH-1:0] mMem [DEPTH];
  int mW = 0;
  int mR = 0;
  int mCount = 0;
  logic             eValid = 1'b0;
  logic [WIDTH-1:0] eData  = '0;

  function automatic logic [WIDTH+3:0] expVec();
    return {mCount == 0, mCount == DEPTH, mCount > HALF, eValid, eData};
  endfunction

  task automatic check(input string tag, input logic [WIDTH+3:0] act, input logic [WIDTH+3:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: {empty,full,halfFull,rdValid,rdData} actual=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [WIDTH+3:0] actVec();
    return {empty, full, halfFull, rdValid, rdData};
  endfunction

  task automatic modelStep(input bit we, input bit re, input bit rw, input logic [WIDTH-1:0] d);
    bit wDo, rDo;
    wDo = we && (mCount != DEPTH);
    rDo = re && (mCount != 0);
    eValid = rDo;
    eData  = rDo ? mMem[mR] : '0;
    if (rw && !we && !re) begin
      mR = 0;
      mCount = mW;
    end else begin
      if (wDo) begin mMem[mW] = d; mW = (mW + 1) % DEPTH; end
      if (rDo) mR = (mR + 1) % DEPTH;
      mCount = mCount + (wDo ? 1 : 0) - (rDo ? 1 : 0);
    end
  endtask

  // One clock: drive at the falling edge, update the model at the rising edge, compare at the next falling edge.
  task automatic step(input bit we, input bit re, input bit rw, input logic [WIDTH-1:0] d, input string tag);
    wrEn = we; rdEn = re; rewind = rw; wrData = d;
    @(posedge clk);
    modelStep(we, re, rw, d);
    @(negedge clk);
    check(tag, actVec(), expVec());
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 0; rdEn = 0; rewind = 0; wrData = '0;
    repeat (2) @(negedge clk);
    // R1: state while reset is held
    mW = 0; mR = 0; mCount = 0; eValid = 0; eData = '0;
    check("R1", actVec(), expVec());
    rstN = 1'b1;
    step(0, 0, 0, '0, "R1");
  endtask

  initial begin
    void'($urandom(32'h5eed_0011));
    doReset();

    // R3: read on empty does nothing
    step(0, 1, 0, '0, "R3");
    step(0, 1, 0, '0, "R3");

    // R2: order and latency; R9: idle cycles show zero
    for (int i = 0; i < 5; i++) step(1, 0, 0, WIDTH'(9'h101 + i*3), "R2");
    step(0, 0, 0, '0, "R9");
    for (int i = 0; i < 5; i++) step(0, 1, 0, '0, "R2");
    step(0, 0, 0, '0, "R9");

    // R8: read+write together while empty performs the write only
    step(1, 1, 0, 9'h1a5, "R8");
    step(0, 1, 0, '0, "R8");
    step(0, 0, 0, '0, "R3");

    // R4 R5: fill to full, crossing the half boundary
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, WIDTH'(i ^ 9'h0f0), "R4 R5");
    // R4: writes while full are dropped
    step(1, 0, 0, 9'h1ff, "R4");
    step(1, 0, 0, 9'h1fe, "R4");
    // R8: read+write while full performs the read only
    step(1, 1, 0, 9'h155, "R8");
    // R10: mid-range read+write keeps the count
    step(1, 1, 0, 9'h0aa, "R10");
    step(1, 1, 0, 9'h0ab, "R10");
    // R5: drain through the half boundary and on to empty
    for (int i = 0; i < DEPTH + 2; i++) step(0, 1, 0, '0, "R5");

    // R6: rewind replays from the first word after reset
    doReset();
    for (int i = 0; i < 10; i++) step(1, 0, 0, WIDTH'(9'h040 + i), "R6");
    for (int i = 0; i < 4; i++) step(0, 1, 0, '0, "R6");
    step(0, 0, 1, '0, "R6");
    for (int i = 0; i < 10; i++) step(0, 1, 0, '0, "R6");
    step(0, 1, 0, '0, "R6");

    // R7: rewind with a strobe active is ignored
    step(0, 0, 1, '0, "R6");
    for (int i = 0; i < 3; i++) step(0, 1, 0, '0, "R7");
    step(0, 1, 1, '0, "R7");
    step(0, 1, 0, '0, "R7");
    step(1, 0, 1, 9'h133, "R7");
    for (int i = 0; i < 8; i++) step(0, 1, 0, '0, "R7");

    // R6: rewind on a full buffer sees write pointer at zero, so it reads empty
    doReset();
    for (int i = 0; i < DEPTH; i++) step(1, 0, 0, WIDTH'(i), "R4");
    step(0, 0, 1, '0, "R6");

    // R10 and the rest: random mix with overlapping strobes
    doReset();
    for (int i = 0; i < 6000; i++) begin
      bit we, re, rw;
      we = ($urandom % 100) < 55;
      re = ($urandom % 100) < 48;
      rw = ($urandom % 100) < 2;
      step(we, re, rw, WIDTH'($urandom), "R10");
    end
    for (int i = 0; i < DEPTH + 1; i++) step(0, 1, 0, '0, "R2");

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

endmodule